// File: doc/BRIEF.md
# Dynamic Range Compressor Gain Controller

This block decides, once per audio frame, how much attenuation a digital volume stage should apply. Each frame it takes one signed level measurement in dB and compares it with a programmable threshold. A hysteresis band around that threshold decides when compression switches on and off. While compression is on, the attenuation grows by an attack step every frame. After the level has dropped, an optional hold period passes. Then the attenuation shrinks by a decay step every frame until the stage is back at its programmed volume, which is zero attenuation.

Level samples arrive on a valid/ready stream. `lvl_ready` is high whenever the block is out of reset, so the block never applies back-pressure. A beat is taken on every cycle in which `lvl_valid` is high. The attenuation result has no ready signal. It is a registered value that changes only in the cycle after a beat has been taken. `atten_valid` pulses for that one cycle, so the consumer can take the value at that pulse or at any later time.

Settings are plain pins and may change between frames. The block reads them on the accepted beat. The level and the threshold are signed Q8.8 dB, and the hysteresis is unsigned Q7.8 dB. The attenuation is unsigned with 24 fractional bits, so 1 dB is 2^24.

Top module: `drc_gain_ctrl`

## Requirements
- R1: Compression starts only on a beat whose level is strictly greater than threshold plus hysteresis, and that beat adds one attack step to the attenuation.
- R2: While compressing, each beat with a level strictly above the threshold adds one attack step. A beat with a level between threshold minus hysteresis and the threshold, inclusive, leaves the attenuation unchanged.
- R3: Compression ends only on a beat whose level is strictly below threshold minus hysteresis, and the attenuation is unchanged on that beat. With a hysteresis of zero, the bare threshold is the boundary in both directions.
- R4: The attack step for a 4-bit code k is 4 dB shifted right by k + floor(k/4) bits. Code 0 is 2^26, code 2 is 2^24 and code 15 is 2^8.
- R5: The decay step for a 4-bit code k is 2^-6 dB shifted right by k bits, which is 2^18 >> k.
- R6: A 4-bit hold code n keeps the attenuation unchanged for 64·n beats after the release beat. Decay then starts on beat 64·n+1 after the release beat. With n = 0, decay starts on the very next beat.
- R7: A beat whose level is above threshold plus hysteresis, arriving during hold or decay, returns the block to attack and adds one attack step on that beat. It also clears the hold count, and this takes priority over a hold period expiring on the same beat.
- R8: Decay never takes the attenuation below zero. When it reaches zero the block goes idle and stays at zero until a new activation.
- R9: The attenuation saturates at the limit of 48 dB (805306368).
- R10: A beat taken while `drc_en` is low forces the attenuation to zero and the block to idle. Changing `drc_en` without a beat has no effect.
- R11: The attenuation changes only in the cycle after a beat is taken. `atten_valid` is high for exactly that cycle, and `lvl_ready` is high whenever reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drc_en | input | 1 | Compression enable; low clears the attenuation on the next beat |
| cfg_thresh | input | 16 | Threshold, signed Q8.8 dB |
| cfg_hyst | input | 15 | Hysteresis, unsigned Q7.8 dB |
| cfg_hold | input | 4 | Hold code n (64·n beats) |
| cfg_attack | input | 4 | Attack rate code |
| cfg_decay | input | 4 | Decay rate code |
| lvl_valid | input | 1 | Level beat valid |
| lvl_ready | output | 1 | Level beat ready (high out of reset) |
| lvl_db | input | 16 | Level, signed Q8.8 dB |
| atten_db | output | 30 | Applied attenuation, unsigned, 24 fractional bits |
| atten_valid | output | 1 | One-cycle pulse after each accepted beat |

## Verification
Two events can land on the same beat: the expiry of a hold period and a new over-threshold level that restarts attack. The bench provokes this by sending exactly 63 low beats after a release with hold code 1, followed by a high beat. That beat must add an attack step instead of entering decay, and the beat after it, whose level lies between the threshold and threshold plus hysteresis, must keep attacking. A second collision is a disable arriving on a beat whose level would otherwise push the attenuation up. There, the bench expects zero in the very next cycle.

// File: rtl/drc_pkg.sv
package drc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ATTACK = 2'd1,
    PH_HOLD   = 2'd2,
    PH_DECAY  = 2'd3
  } drc_phase_e;

  typedef enum logic [1:0] {
    OP_KEEP  = 2'd0,
    OP_ADD   = 2'd1,
    OP_SUB   = 2'd2,
    OP_CLEAR = 2'd3
  } gain_op_e;

  typedef struct packed {
    logic above_on;   // level > thresh + hyst
    logic above_thr;  // level > thresh
    logic below_off;  // level < thresh - hyst
  } lvl_flags_t;

endpackage

// File: rtl/drc_level_cmp.sv
module drc_level_cmp
  import drc_pkg::*;
#(
  parameter int LVL_W = 16,
  parameter int HYS_W = 15
) (
  input  logic signed [LVL_W-1:0] level,
  input  logic signed [LVL_W-1:0] thresh,
  input  logic        [HYS_W-1:0] hyst,
  output lvl_flags_t              flags
);

  localparam int EW = LVL_W + 2;

  logic signed [EW-1:0] lv_x;
  logic signed [EW-1:0] th_x;
  logic signed [EW-1:0] hy_x;
  logic signed [EW-1:0] on_lim;
  logic signed [EW-1:0] off_lim;

  always_comb begin
    lv_x    = EW'(level);
    th_x    = EW'(thresh);
    hy_x    = signed'({{(EW-HYS_W){1'b0}}, hyst});
    on_lim  = th_x + hy_x;
    off_lim = th_x - hy_x;
    flags.above_on  = (lv_x > on_lim);
    flags.above_thr = (lv_x > th_x);
    flags.below_off = (lv_x < off_lim);
  end

endmodule

// File: rtl/drc_step_table.sv
module drc_step_table #(
  parameter int ACC_W  = 30,
  parameter int FRAC_W = 24,
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] atk_code,
  input  logic [CODE_W-1:0] dcy_code,
  output logic [ACC_W-1:0]  atk_step,
  output logic [ACC_W-1:0]  dcy_step
);

  localparam int NCODE = 1 << CODE_W;
  // fastest attack: 4 dB per frame; fastest decay: 2^-6 dB per frame
  localparam logic [ACC_W-1:0] ATK_BASE = ACC_W'(4) << FRAC_W;
  localparam logic [ACC_W-1:0] DCY_BASE = ACC_W'(1) << (FRAC_W - 6);

  logic [ACC_W-1:0] atk_tab [NCODE];
  logic [ACC_W-1:0] dcy_tab [NCODE];

  for (genvar i = 0; i < NCODE; i++) begin : g_rate
    localparam int ASH = i + i / 4;
    assign atk_tab[i] = ATK_BASE >> ASH;
    assign dcy_tab[i] = DCY_BASE >> i;
  end

  assign atk_step = atk_tab[atk_code];
  assign dcy_step = dcy_tab[dcy_code];

endmodule

// File: rtl/drc_atten_acc.sv
module drc_atten_acc
  import drc_pkg::*;
#(
  parameter int               ACC_W     = 30,
  parameter logic [ACC_W-1:0] ATT_LIMIT = '1
) (
  input  logic [ACC_W-1:0] cur,
  input  logic [ACC_W-1:0] atk_step,
  input  logic [ACC_W-1:0] dcy_step,
  input  gain_op_e         op,
  output logic [ACC_W-1:0] nxt,
  output logic             dcy_floor
);

  logic [ACC_W:0] sum;

  always_comb begin
    sum       = {1'b0, cur} + {1'b0, atk_step};
    dcy_floor = (dcy_step >= cur);
    unique case (op)
      OP_ADD:   nxt = (sum > {1'b0, ATT_LIMIT}) ? ATT_LIMIT : sum[ACC_W-1:0];
      OP_SUB:   nxt = dcy_floor ? '0 : (cur - dcy_step);
      OP_CLEAR: nxt = '0;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/drc_gain_ctrl.sv
module drc_gain_ctrl
  import drc_pkg::*;
#(
  parameter int LVL_W      = 16,
  parameter int HYS_W      = 15,
  parameter int CODE_W     = 4,
  parameter int INT_W      = 6,
  parameter int FRAC_W     = 24,
  parameter int ATT_MAX_DB = 48,
  parameter int HOLD_UNIT  = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    drc_en,
  input  logic signed [LVL_W-1:0] cfg_thresh,
  input  logic        [HYS_W-1:0] cfg_hyst,
  input  logic       [CODE_W-1:0] cfg_hold,
  input  logic       [CODE_W-1:0] cfg_attack,
  input  logic       [CODE_W-1:0] cfg_decay,
  input  logic                    lvl_valid,
  output logic                    lvl_ready,
  input  logic signed [LVL_W-1:0] lvl_db,
  output logic [INT_W+FRAC_W-1:0] atten_db,
  output logic                    atten_valid
);

  localparam int ACC_W  = INT_W + FRAC_W;
  localparam int HCNT_W = CODE_W + $clog2(HOLD_UNIT);
  localparam logic [ACC_W-1:0] ATT_LIMIT = ACC_W'(ATT_MAX_DB) << FRAC_W;

  drc_phase_e        phase_q, phase_d;
  gain_op_e          op;
  lvl_flags_t        flags;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [ACC_W-1:0]  atk_step, dcy_step;
  logic              dcy_floor;
  logic [HCNT_W-1:0] hold_q, hold_d, hold_lim;
  logic              ready_q;
  logic              beat;

  assign beat     = lvl_valid && ready_q;
  assign hold_lim = HCNT_W'(cfg_hold) * HCNT_W'(HOLD_UNIT);

  drc_level_cmp #(
    .LVL_W (LVL_W),
    .HYS_W (HYS_W)
  ) u_cmp (
    .level  (lvl_db),
    .thresh (cfg_thresh),
    .hyst   (cfg_hyst),
    .flags  (flags)
  );

  drc_step_table #(
    .ACC_W  (ACC_W),
    .FRAC_W (FRAC_W),
    .CODE_W (CODE_W)
  ) u_steps (
    .atk_code (cfg_attack),
    .dcy_code (cfg_decay),
    .atk_step (atk_step),
    .dcy_step (dcy_step)
  );

  drc_atten_acc #(
    .ACC_W     (ACC_W),
    .ATT_LIMIT (ATT_LIMIT)
  ) u_acc (
    .cur       (acc_q),
    .atk_step  (atk_step),
    .dcy_step  (dcy_step),
    .op        (op),
    .nxt       (acc_d),
    .dcy_floor (dcy_floor)
  );

  // next-phase and accumulator operation for the current beat
  always_comb begin
    phase_d = phase_q;
    op      = OP_KEEP;
    hold_d  = hold_q;
    if (!drc_en) begin
      phase_d = PH_IDLE;
      op      = OP_CLEAR;
      hold_d  = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (flags.above_on) begin
            phase_d = PH_ATTACK;
            op      = OP_ADD;
          end
        end
        PH_ATTACK: begin
          if (flags.above_thr) begin
            op = OP_ADD;
          end else if (flags.below_off) begin
            hold_d  = '0;
            phase_d = (cfg_hold == '0) ? PH_DECAY : PH_HOLD;
          end
        end
        PH_HOLD: begin
          if (flags.above_on) begin
            phase_d = PH_ATTACK;
            op      = OP_ADD;
            hold_d  = '0;
          end else if ((hold_q + 1'b1) >= hold_lim) begin
            phase_d = PH_DECAY;
            hold_d  = '0;
          end else begin
            hold_d = hold_q + 1'b1;
          end
        end
        PH_DECAY: begin
          if (flags.above_on) begin
            phase_d = PH_ATTACK;
            op      = OP_ADD;
          end else begin
            op = OP_SUB;
            if (dcy_floor) phase_d = PH_IDLE;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      acc_q       <= '0;
      hold_q      <= '0;
      ready_q     <= 1'b0;
      atten_valid <= 1'b0;
    end else begin
      ready_q     <= 1'b1;
      atten_valid <= beat;
      if (beat) begin
        phase_q <= phase_d;
        acc_q   <= acc_d;
        hold_q  <= hold_d;
      end
    end
  end

  assign lvl_ready = ready_q;
  assign atten_db  = acc_q;

endmodule

// File: rtl/drc_gain_ctrl_chk.sv
module drc_gain_ctrl_chk #(
  parameter int LVL_W      = 16,
  parameter int HYS_W      = 15,
  parameter int ACC_W      = 30,
  parameter int FRAC_W     = 24,
  parameter int ATT_MAX_DB = 48
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    drc_en,
  input logic signed [LVL_W-1:0] cfg_thresh,
  input logic        [HYS_W-1:0] cfg_hyst,
  input logic                    lvl_valid,
  input logic                    lvl_ready,
  input logic signed [LVL_W-1:0] lvl_db,
  input logic [ACC_W-1:0]        atten_db,
  input logic                    atten_valid
);

  localparam int EW = LVL_W + 2;
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(ATT_MAX_DB) << FRAC_W;

  logic                 take;
  logic signed [EW-1:0] lv_e, hi_e, lo_e;

  assign take = lvl_valid && lvl_ready;
  assign lv_e = EW'(lvl_db);
  assign hi_e = EW'(cfg_thresh) + signed'({{(EW-HYS_W){1'b0}}, cfg_hyst});
  assign lo_e = EW'(cfg_thresh) - signed'({{(EW-HYS_W){1'b0}}, cfg_hyst});

  // R1
  rise_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && drc_en && (lv_e > hi_e)) |=> (atten_db >= $past(atten_db)));

  // R3
  low_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && drc_en && (lv_e < lo_e)) |=> (atten_db <= $past(atten_db)));

  // R9
  limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    atten_db <= LIMIT);

  // R10
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !drc_en) |=> (atten_db == '0));

  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(atten_db));

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> atten_valid);

  // R11
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !atten_valid);

endmodule

bind drc_gain_ctrl drc_gain_ctrl_chk #(
  .LVL_W      (LVL_W),
  .HYS_W      (HYS_W),
  .ACC_W      (INT_W + FRAC_W),
  .FRAC_W     (FRAC_W),
  .ATT_MAX_DB (ATT_MAX_DB)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .drc_en      (drc_en),
  .cfg_thresh  (cfg_thresh),
  .cfg_hyst    (cfg_hyst),
  .lvl_valid   (lvl_valid),
  .lvl_ready   (lvl_ready),
  .lvl_db      (lvl_db),
  .atten_db    (atten_db),
  .atten_valid (atten_valid)
);

// File: tb/drc_gain_ctrl_bench.sv
`timescale 1ns/1ps
module drc_gain_ctrl_bench;

  localparam logic [29:0] DB1   = 30'd16777216;
  localparam logic [29:0] DMAX  = 30'd805306368;
  localparam logic [29:0] DSTEP = 30'd262144;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        drc_en = 1'b1;
  logic [15:0] cfg_thresh = 16'hF400;  // -12 dB
  logic [14:0] cfg_hyst = 15'd768;     // 3 dB
  logic [3:0]  cfg_hold = 4'd0;
  logic [3:0]  cfg_attack = 4'd2;
  logic [3:0]  cfg_decay = 4'd0;
  logic        lvl_valid = 1'b0;
  logic        lvl_ready;
  logic [15:0] lvl_db = 16'h0000;
  logic [29:0] atten_db;
  logic        atten_valid;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  drc_gain_ctrl u_drc_gain_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .drc_en      (drc_en),
    .cfg_thresh  (cfg_thresh),
    .cfg_hyst    (cfg_hyst),
    .cfg_hold    (cfg_hold),
    .cfg_attack  (cfg_attack),
    .cfg_decay   (cfg_decay),
    .lvl_valid   (lvl_valid),
    .lvl_ready   (lvl_ready),
    .lvl_db      (lvl_db),
    .atten_db    (atten_db),
    .atten_valid (atten_valid)
  );

  task automatic chk(input string req, input logic [29:0] act, input logic [29:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one beat; returns at the negedge after the capturing edge
  task automatic beat(input int lvl);
    @(negedge clk);
    lvl_db    = 16'(lvl);
    lvl_valid = 1'b1;
    @(negedge clk);
    lvl_valid = 1'b0;
  endtask

  task automatic clear_state();
    drc_en = 1'b0;
    beat(-8000);
    drc_en = 1'b1;
  endtask

  task automatic t_reset();
    chk("R11 reset atten", atten_db, '0);
    chk("R11 reset valid", 30'(atten_valid), '0);
    chk("R11 ready out of reset", 30'(lvl_ready), 30'd1);
  endtask

  task automatic t_activation();
    clear_state();
    cfg_attack = 4'd2; cfg_decay = 4'd0; cfg_hold = 4'd0; cfg_hyst = 15'd768;
    beat(-2304);
    chk("R1 at on-limit no start", atten_db, '0);
    beat(-2303);
    chk("R1 R4 start code2", atten_db, DB1);
    chk("R11 valid pulse", 30'(atten_valid), 30'd1);
  endtask

  task automatic t_attack();
    beat(-3071);
    chk("R2 above thr attacks", atten_db, 2 * DB1);
    beat(-3300);
    chk("R2 band holds", atten_db, 2 * DB1);
    beat(-3072);
    chk("R2 at thr holds", atten_db, 2 * DB1);
    beat(-2000);
    chk("R2 attack again", atten_db, 3 * DB1);
  endtask

  task automatic t_release();
    beat(-3840);
    chk("R3 at off-limit stays", atten_db, 3 * DB1);
    beat(-3841);
    chk("R3 release beat unchanged", atten_db, 3 * DB1);
    beat(-3841);
    chk("R5 R6 decay code0 next beat", atten_db, 3 * DB1 - DSTEP);
    beat(-3000);
    chk("R5 decay continues in band", atten_db, 3 * DB1 - 2 * DSTEP);
    cfg_decay = 4'd3;
    beat(-4000);
    chk("R5 decay code3", atten_db, 3 * DB1 - 2 * DSTEP - 30'd32768);
  endtask

  task automatic t_decay_floor();
    clear_state();
    cfg_attack = 4'd15; cfg_decay = 4'd0; cfg_hold = 4'd0;
    beat(-2000);
    chk("R4 attack code15", atten_db, 30'd256);
    beat(-4000);
    beat(-4000);
    chk("R8 decay floors at zero", atten_db, '0);
    beat(-4000);
    chk("R8 idle stays zero", atten_db, '0);
    beat(-3000);
    chk("R8 idle band no start", atten_db, '0);
  endtask

  task automatic t_hold();
    clear_state();
    cfg_attack = 4'd2; cfg_decay = 4'd0; cfg_hold = 4'd1;
    beat(-2000);
    beat(-4000);
    for (int i = 0; i < 64; i++) begin
      beat(-4000);
      chk("R6 hold keeps gain", atten_db, DB1);
    end
    beat(-4000);
    chk("R6 decay after hold", atten_db, DB1 - DSTEP);
  endtask

  task automatic t_hold_restart();
    clear_state();
    cfg_hold = 4'd1;
    beat(-2000);
    beat(-4000);
    for (int i = 0; i < 30; i++) beat(-4000);
    beat(-2300);
    chk("R7 reattack in hold", atten_db, 2 * DB1);
    beat(-4000);
    for (int i = 0; i < 64; i++) beat(-4000);
    chk("R7 hold counter restarted", atten_db, 2 * DB1);
    beat(-4000);
    chk("R7 decay after full hold", atten_db, 2 * DB1 - DSTEP);
    beat(-2000);
    chk("R7 reattack in decay", atten_db, 3 * DB1 - DSTEP);
  endtask

  task automatic t_collision();
    clear_state();
    cfg_hold = 4'd1;
    beat(-2000);
    beat(-4000);
    for (int i = 0; i < 63; i++) beat(-4000);
    beat(-2000);
    chk("R7 attack wins over hold expiry", atten_db, 2 * DB1);
    beat(-2500);
    chk("R7 still attacking after collision", atten_db, 3 * DB1);
  endtask

  task automatic t_hyst_zero();
    clear_state();
    cfg_hold = 4'd0; cfg_hyst = '0;
    beat(-3072);
    chk("R3 zero hyst at thr no start", atten_db, '0);
    beat(-3071);
    chk("R3 zero hyst start", atten_db, DB1);
    beat(-3072);
    chk("R3 zero hyst at thr holds", atten_db, DB1);
    beat(-3073);
    beat(-3073);
    chk("R3 zero hyst release then decay", atten_db, DB1 - DSTEP);
    cfg_hyst = 15'd768;
  endtask

  task automatic t_limit();
    clear_state();
    cfg_attack = 4'd0;
    for (int i = 0; i < 12; i++) beat(-2000);
    chk("R4 R9 code0 reaches limit", atten_db, DMAX);
    beat(-2000);
    chk("R9 saturates at limit", atten_db, DMAX);
  endtask

  task automatic t_disable();
    drc_en = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 no beat no effect", atten_db, DMAX);
    beat(-2000);
    chk("R10 disable beat clears", atten_db, '0);
    drc_en = 1'b1;
    beat(-2500);
    chk("R10 idle after disable", atten_db, '0);
  endtask

  task automatic t_quiet();
    clear_state();
    cfg_attack = 4'd2;
    beat(-2000);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cfg_attack = 4'(i);
      lvl_db = 16'(-1000);
      chk("R11 held between beats", atten_db, DB1);
      chk("R11 valid low between beats", 30'(atten_valid), '0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_activation();
    t_attack();
    t_release();
    t_decay_floor();
    t_hold();
    t_hold_restart();
    t_collision();
    t_hyst_zero();
    t_limit();
    t_disable();
    t_quiet();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule